// File: doc/BRIEF.md
# DDR3 Power-Up Initialisation Sequencer

This block walks one DDR3 channel from power-up to a calibrated idle state. A start strobe latches the timing inputs (tAA, tWR, tCWL in clocks), the map of ranks present, a two-DIMMs-per-channel flag and a write-termination select. The block then drives the DRAM reset, clock enable, per-rank CKE and an ODT-low override through a fixed series of counted waits. After that it hands five commands, one at a time, to a downstream command issuer over a request/acknowledge handshake: four mode-register writes and one long ZQ calibration.

The mode-register contents are computed from the latched timing inputs. On a resume from suspend the DRAM contents must be kept, so a start with the resume flag set finishes at once and leaves the pins alone. Every wait length is a parameter given in core-clock cycles, so a bench can use scaled-down values. An issuer error, a missing acknowledge or an illegal timing input stops the sequence with an error code.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: A start with `resume` high sets `done` in the next cycle, keeps `reset_n` high and makes no command request.
- R2: A start with tWR outside 5..16 or tAA below 4 sets `error` with `err_code` 1 in the next cycle, with no reset pulse and no request.
- R3: On a valid start, `reset_n` is low for exactly T_RESET cycles, and during that time all CKE bits and `clk_en` are low.
- R4: `clk_en` rises T_STAB cycles after `reset_n` rises. CKE rises T_CKSRX cycles after `clk_en`, and only on the bits set in the latched rank map.
- R5: The first command request rises T_XPR cycles after CKE rises.
- R6: Five requests are made in order. Four are mode-register writes (`cmd_is_zq`=0) to banks 2, 3, 1, 0. The last is a ZQ calibration (`cmd_is_zq`=1) on bank 0 with address 0x0400 (A10 set). A request's payload holds still until it is answered.
- R7: The bank-0 word has CAS code c=tAA-4 with c[2:0] in bits 6:4 and c[3] in bit 2. Bit 8 (DLL reset) is 1 and bits 1:0 are 0. Bits 11:9 hold the write-recovery code for tWR 5..16: 1,2,3,4,5,5,6,6,7,7,0,0.
- R8: The bank-1 word is 0x0002 (driver impedance bit 1, DLL enabled, no additive latency). It is 0x0006 when `two_dpc` is set, which adds termination bit 2 only.
- R9: The bank-2 word holds tCWL-5 in bits 5:3 and a write-termination code in bits 10:9: 1 when `rtt_wr_120` is 0, 2 when it is 1. The bank-3 word is 0x0000.
- R10: `odt_hold` is high from the cycle reset is asserted until the last request is answered or the run fails, and it is low afterwards.
- R11: An asserted `cmd_err` while a request is pending stops the sequence with `err_code` 2, and no further request follows.
- R12: A request left unanswered for ACK_TIMEOUT cycles is dropped and the sequence stops with `err_code` 3.
- R13: `busy` is high from the cycle after a valid start until `done` or `error` rises, and is never high together with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when not busy) |
| resume | input | 1 | Suspend-resume boot: skip the sequence |
| t_aa | input | 5 | CAS latency in clocks |
| t_wr | input | 5 | Write recovery in clocks |
| t_cwl | input | 4 | CAS write latency in clocks |
| rank_map | input | NRANK | Ranks present |
| two_dpc | input | 1 | Two DIMMs share the channel |
| rtt_wr_120 | input | 1 | Select 120 ohm write termination instead of 60 ohm |
| reset_n | output | 1 | DRAM reset, active low |
| cke | output | NRANK | Per-rank clock enable |
| clk_en | output | 1 | DRAM clock enable |
| odt_hold | output | 1 | Override forcing ODT low on all ranks |
| cmd_req | output | 1 | Command request to the issuer |
| cmd_is_zq | output | 1 | 1 = ZQ calibration, 0 = mode-register write |
| cmd_bank | output | 3 | Bank address of the command |
| cmd_addr | output | 16 | Address bus value of the command |
| cmd_ack | input | 1 | Issuer completed the request |
| cmd_err | input | 1 | Issuer failed the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully (held until next start) |
| error | output | 1 | Sequence stopped on an error (held until next start) |
| err_code | output | 2 | 0 none, 1 bad timing input, 2 issuer error, 3 acknowledge timeout |

## Verification
The hardest states to reach are the failures in the middle of a command run. The issuer error must land on one chosen request, and the timeout needs a request that is never answered. From the ports these only happen after the full reset and clock waits have gone by. The bench's issuer model therefore takes a mode: it can answer after a random delay, raise the error on a chosen request index, or never answer. A valid run follows each failure, which shows that the latched error clears on the next start.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    localparam int N_STEPS = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_STAB,
        ST_CKSRX,
        ST_XPR,
        ST_CMD,
        ST_GAP,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_PARAM   = 2'd1,
        ERR_ISSUER  = 2'd2,
        ERR_TIMEOUT = 2'd3
    } err_code_t;

    typedef enum logic {
        CMD_MRS = 1'b0,
        CMD_ZQ  = 1'b1
    } cmd_kind_t;

    typedef struct packed {
        logic [4:0] t_aa;
        logic [4:0] t_wr;
        logic [3:0] t_cwl;
        logic       two_dpc;
        logic       rtt_wr_120;
    } timing_cfg_t;

    typedef struct packed {
        cmd_kind_t   kind;
        logic [2:0]  bank;
        logic [15:0] addr;
    } cmd_word_t;

    // Write-recovery field code for tWR in clocks
    function automatic logic [2:0] wr_code(input logic [4:0] t_wr);
        case (t_wr)
            5'd5:          return 3'd1;
            5'd6:          return 3'd2;
            5'd7:          return 3'd3;
            5'd8:          return 3'd4;
            5'd9,  5'd10:  return 3'd5;
            5'd11, 5'd12:  return 3'd6;
            5'd13, 5'd14:  return 3'd7;
            default:       return 3'd0;
        endcase
    endfunction

    function automatic logic cfg_ok(input timing_cfg_t cfg);
        return (cfg.t_wr >= 5'd5) && (cfg.t_wr <= 5'd16) && (cfg.t_aa >= 5'd4);
    endfunction

    // Bank (mode register number) per step: order 2,3,1,0 then ZQ on bank 0
    function automatic logic [2:0] step_bank(input int step);
        case (step)
            0:       return 3'd2;
            1:       return 3'd3;
            2:       return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/ddr3_wait_timer.sv
module ddr3_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr3_mr_encoder.sv
module ddr3_mr_encoder
    import ddr3_init_pkg::*;
(
    input  timing_cfg_t cfg,
    output cmd_word_t   words [N_STEPS]
);
    function automatic logic [15:0] mr0_bits(input timing_cfg_t c);
        logic [15:0] r;
        logic [4:0]  cas;
        cas    = c.t_aa - 5'd4;
        r      = '0;
        r[11:9] = wr_code(c.t_wr);
        r[8]    = 1'b1;
        r[6:4]  = cas[2:0];
        r[2]    = cas[3];
        return r;
    endfunction

    function automatic logic [15:0] mr1_bits(input timing_cfg_t c);
        logic [15:0] r;
        r    = '0;
        r[1] = 1'b1;
        r[2] = c.two_dpc;
        return r;
    endfunction

    function automatic logic [15:0] mr2_bits(input timing_cfg_t c);
        logic [15:0] r;
        logic [3:0]  cwl;
        cwl     = c.t_cwl - 4'd5;
        r       = '0;
        r[5:3]  = cwl[2:0];
        r[10:9] = c.rtt_wr_120 ? 2'd2 : 2'd1;
        return r;
    endfunction

    function automatic logic [15:0] step_addr(input int step, input timing_cfg_t c);
        case (step)
            0:       return mr2_bits(c);
            1:       return 16'h0000;
            2:       return mr1_bits(c);
            3:       return mr0_bits(c);
            default: return 16'h0400;
        endcase
    endfunction

    for (genvar s = 0; s < N_STEPS; s++) begin : g_step
        assign words[s].kind = (s == N_STEPS - 1) ? CMD_ZQ : CMD_MRS;
        assign words[s].bank = step_bank(s);
        assign words[s].addr = step_addr(s, cfg);
    end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
    import ddr3_init_pkg::*;
#(
    parameter int NRANK       = 4,
    parameter int T_RESET     = 20000,
    parameter int T_STAB      = 50000,
    parameter int T_CKSRX     = 2,
    parameter int T_XPR       = 30,
    parameter int ACK_TIMEOUT = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             resume,
    input  logic [4:0]       t_aa,
    input  logic [4:0]       t_wr,
    input  logic [3:0]       t_cwl,
    input  logic [NRANK-1:0] rank_map,
    input  logic             two_dpc,
    input  logic             rtt_wr_120,
    output logic             reset_n,
    output logic [NRANK-1:0] cke,
    output logic             clk_en,
    output logic             odt_hold,
    output logic             cmd_req,
    output logic             cmd_is_zq,
    output logic [2:0]       cmd_bank,
    output logic [15:0]      cmd_addr,
    input  logic             cmd_ack,
    input  logic             cmd_err,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [1:0]       err_code
);
    localparam int M1   = (T_RESET > T_STAB) ? T_RESET : T_STAB;
    localparam int M2   = (T_CKSRX > T_XPR) ? T_CKSRX : T_XPR;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXW = (M3 > ACK_TIMEOUT) ? M3 : ACK_TIMEOUT;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int IW   = $clog2(N_STEPS + 1);
    localparam logic [IW-1:0] LAST_STEP = IW'(N_STEPS - 1);

    seq_state_t       state, state_n;
    timing_cfg_t      cfg_in, cfg_q;
    logic [NRANK-1:0] ranks_q;
    logic [IW-1:0]    idx;
    logic             reset_n_q, clk_q, odt_q, done_q, fail_q;
    logic [NRANK-1:0] cke_q;
    err_code_t        code_q;
    cmd_word_t        words [N_STEPS];
    cmd_word_t        cur;

    logic             wt_load, wt_zero, to_load, to_zero;
    logic [CW-1:0]    wt_val;
    logic             idle_like, go;

    assign cfg_in = '{t_aa: t_aa, t_wr: t_wr, t_cwl: t_cwl,
                      two_dpc: two_dpc, rtt_wr_120: rtt_wr_120};

    ddr3_mr_encoder u_enc (
        .cfg   (cfg_q),
        .words (words)
    );

    ddr3_wait_timer #(.W(CW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wt_load),
        .load_val (wt_val),
        .zero     (wt_zero)
    );

    ddr3_wait_timer #(.W(CW)) u_ack_to (
        .clk      (clk),
        .rst      (rst),
        .load     (to_load),
        .load_val (CW'(ACK_TIMEOUT - 1)),
        .zero     (to_zero)
    );

    assign idle_like = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
    assign go        = idle_like && start;

    always_comb begin
        state_n = state;
        wt_load = 1'b0;
        wt_val  = '0;
        to_load = 1'b0;
        case (state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    if (resume) begin
                        state_n = ST_DONE;
                    end else if (!cfg_ok(cfg_in)) begin
                        state_n = ST_FAIL;
                    end else begin
                        state_n = ST_RST;
                        wt_load = 1'b1;
                        wt_val  = CW'(T_RESET - 1);
                    end
                end
            end
            ST_RST: if (wt_zero) begin
                state_n = ST_STAB;
                wt_load = 1'b1;
                wt_val  = CW'(T_STAB - 1);
            end
            ST_STAB: if (wt_zero) begin
                state_n = ST_CKSRX;
                wt_load = 1'b1;
                wt_val  = CW'(T_CKSRX - 1);
            end
            ST_CKSRX: if (wt_zero) begin
                state_n = ST_XPR;
                wt_load = 1'b1;
                wt_val  = CW'(T_XPR - 1);
            end
            ST_XPR: if (wt_zero) begin
                state_n = ST_CMD;
                to_load = 1'b1;
            end
            ST_CMD: begin
                if (cmd_ack) begin
                    state_n = (idx == LAST_STEP) ? ST_DONE : ST_GAP;
                end else if (cmd_err || to_zero) begin
                    state_n = ST_FAIL;
                end
            end
            ST_GAP: begin
                state_n = ST_CMD;
                to_load = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_q     <= '0;
            ranks_q   <= '0;
            idx       <= '0;
            reset_n_q <= 1'b1;
            cke_q     <= '0;
            clk_q     <= 1'b0;
            odt_q     <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
            code_q    <= ERR_NONE;
        end else begin
            state <= state_n;
            if (go) begin
                cfg_q   <= cfg_in;
                ranks_q <= rank_map;
                idx     <= '0;
                done_q  <= 1'b0;
                fail_q  <= 1'b0;
                code_q  <= ERR_NONE;
                if (resume) begin
                    done_q <= 1'b1;
                end else if (!cfg_ok(cfg_in)) begin
                    fail_q <= 1'b1;
                    code_q <= ERR_PARAM;
                end else begin
                    reset_n_q <= 1'b0;
                    cke_q     <= '0;
                    clk_q     <= 1'b0;
                    odt_q     <= 1'b1;
                end
            end
            if (state == ST_RST && wt_zero)   reset_n_q <= 1'b1;
            if (state == ST_STAB && wt_zero)  clk_q     <= 1'b1;
            if (state == ST_CKSRX && wt_zero) cke_q     <= ranks_q;
            if (state == ST_CMD) begin
                if (cmd_ack) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_STEP) begin
                        done_q <= 1'b1;
                        odt_q  <= 1'b0;
                    end
                end else if (cmd_err) begin
                    fail_q <= 1'b1;
                    code_q <= ERR_ISSUER;
                    odt_q  <= 1'b0;
                end else if (to_zero) begin
                    fail_q <= 1'b1;
                    code_q <= ERR_TIMEOUT;
                    odt_q  <= 1'b0;
                end
            end
        end
    end

    assign cur       = (idx <= LAST_STEP) ? words[idx] : words[0];
    assign cmd_req   = (state == ST_CMD);
    assign cmd_is_zq = cur.kind;
    assign cmd_bank  = cur.bank;
    assign cmd_addr  = cur.addr;
    assign reset_n   = reset_n_q;
    assign cke       = cke_q;
    assign clk_en    = clk_q;
    assign odt_hold  = odt_q;
    assign busy      = !idle_like;
    assign done      = done_q;
    assign error     = fail_q;
    assign err_code  = code_q;
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk #(
    parameter int NRANK = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             resume,
    input logic             reset_n,
    input logic [NRANK-1:0] cke,
    input logic             clk_en,
    input logic             odt_hold,
    input logic             cmd_req,
    input logic [15:0]      cmd_addr,
    input logic             cmd_ack,
    input logic             cmd_err,
    input logic             busy,
    input logic             done,
    input logic             error
);
    p_resume_skip_r1: assert property (@(posedge clk) disable iff (rst)
        (start && resume && !busy) |=> (done && reset_n && !cmd_req));

    p_reset_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !reset_n |-> ((cke == '0) && !clk_en));

    p_clk_before_cke_r4: assert property (@(posedge clk) disable iff (rst)
        (cke != '0) |-> (clk_en && reset_n));

    p_cmd_after_pins_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> (reset_n && clk_en));

    p_payload_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack && !cmd_err) |=> (!cmd_req || $stable(cmd_addr)));

    p_odt_during_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> odt_hold);

    p_no_req_after_err_r11: assert property (@(posedge clk) disable iff (rst)
        error |-> !cmd_req);

    p_busy_exclusive_r13: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!done && !error));
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk #(.NRANK(NRANK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .resume   (resume),
    .reset_n  (reset_n),
    .cke      (cke),
    .clk_en   (clk_en),
    .odt_hold (odt_hold),
    .cmd_req  (cmd_req),
    .cmd_addr (cmd_addr),
    .cmd_ack  (cmd_ack),
    .cmd_err  (cmd_err),
    .busy     (busy),
    .done     (done),
    .error    (error)
);

// File: tb/tb_ddr3_pwrup_seq.sv
module tb_ddr3_pwrup_seq;
    localparam int NRANK = 4;
    localparam int TR    = 20;
    localparam int TS    = 30;
    localparam int TC    = 3;
    localparam int TX    = 5;
    localparam int TO    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, resume = 1'b0;
    logic [4:0] t_aa = 5'd6, t_wr = 5'd6;
    logic [3:0] t_cwl = 4'd5;
    logic [NRANK-1:0] rank_map = '0;
    logic two_dpc = 1'b0, rtt_wr_120 = 1'b0;
    logic reset_n, clk_en, odt_hold, cmd_req, cmd_is_zq;
    logic [NRANK-1:0] cke;
    logic [2:0] cmd_bank;
    logic [15:0] cmd_addr;
    logic cmd_ack = 1'b0, cmd_err = 1'b0;
    logic busy, done, error;
    logic [1:0] err_code;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ddr3_pwrup_seq #(
        .NRANK(NRANK), .T_RESET(TR), .T_STAB(TS), .T_CKSRX(TC),
        .T_XPR(TX), .ACK_TIMEOUT(TO)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .resume(resume),
        .t_aa(t_aa), .t_wr(t_wr), .t_cwl(t_cwl), .rank_map(rank_map),
        .two_dpc(two_dpc), .rtt_wr_120(rtt_wr_120),
        .reset_n(reset_n), .cke(cke), .clk_en(clk_en), .odt_hold(odt_hold),
        .cmd_req(cmd_req), .cmd_is_zq(cmd_is_zq), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
        .busy(busy), .done(done), .error(error), .err_code(err_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int k, input int aa, input int wr,
                                    input int cwl, input bit two, input bit r120);
        int a;
        int cas;
        int wc;
        cas = aa - 4;
        if (wr <= 8)       wc = wr - 4;
        else if (wr <= 14) wc = (wr - 9) / 2 + 5;
        else               wc = 0;
        case (k)
            0: a = (((cwl - 5) & 7) << 3) | ((r120 ? 2 : 1) << 9);
            1: a = 0;
            2: a = 2 | (two ? 4 : 0);
            3: a = (wc << 9) | (1 << 8) | ((cas & 7) << 4) | (((cas >> 3) & 1) << 2);
            default: a = 16'h0400;
        endcase
        case (k)
            0: return (2 << 16) | a;
            1: return (3 << 16) | a;
            2: return (1 << 16) | a;
            3: return a;
            default: return (1 << 19) | a;
        endcase
    endfunction

    // mode: 0 answer, 1 error on request err_at, 2 never answer
    task automatic run_seq(input bit rs, input int aa, input int wr, input int cwl,
                           input int rk, input bit two, input bit r120,
                           input int mode, input int err_at);
        int cyc = 0, rst_low = 0, i_rise = -1, i_clk = -1, i_cke = -1, i_req = -1;
        int nreq = 0, req_hi = 0, busy_bad = 0, odt_bad = 0, cke_bad = 0;
        int wcnt = 0;
        bit in_req = 0;
        bit pok;
        int words [8];
        pok = (wr >= 5) && (wr <= 16) && (aa >= 4);
        resume = rs; t_aa = 5'(aa); t_wr = 5'(wr); t_cwl = 4'(cwl);
        rank_map = NRANK'(rk); two_dpc = two; rtt_wr_120 = r120;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || error) && cyc < 2000) begin
            cmd_ack = 1'b0;
            cmd_err = 1'b0;
            if (!reset_n) begin
                rst_low++;
                if (cke != '0 || clk_en) cke_bad++;
            end
            if (reset_n && rst_low > 0 && i_rise < 0) i_rise = cyc;
            if (clk_en && rst_low > 0 && i_clk < 0) i_clk = cyc;
            if (cke != '0 && i_cke < 0) i_cke = cyc;
            if (!busy) busy_bad++;
            if (rst_low > 0 && !odt_hold) odt_bad++;
            if (cmd_req) begin
                req_hi++;
                if (!in_req) begin
                    if (i_req < 0) i_req = cyc;
                    if (nreq < 8) words[nreq] = {12'd0, cmd_is_zq, cmd_bank, cmd_addr};
                    nreq++;
                    in_req = 1;
                    wcnt = int'($urandom % 3);
                end
                if (mode != 2) begin
                    if (wcnt == 0) begin
                        if (mode == 1 && nreq - 1 == err_at) cmd_err = 1'b1;
                        else cmd_ack = 1'b1;
                        in_req = 0;
                    end else begin
                        wcnt--;
                    end
                end
            end
            @(negedge clk);
            cyc++;
        end
        cmd_ack = 1'b0;
        cmd_err = 1'b0;
        if (rs) begin
            check(done && !error, "R1 done after resume", int'(done), 1);
            check(cyc == 0, "R1 immediate finish", cyc, 0);
            check(reset_n && rst_low == 0, "R1 no reset pulse", rst_low, 0);
            check(nreq == 0 && !cmd_req, "R1 no command", nreq, 0);
        end else if (!pok) begin
            check(error && err_code == 2'd1, "R2 param error code", int'(err_code), 1);
            check(cyc == 0 && rst_low == 0, "R2 no reset pulse", rst_low, 0);
            check(nreq == 0 && !busy, "R2 no command", nreq, 0);
        end else begin
            check(rst_low == TR, "R3 reset low length", rst_low, TR);
            check(cke_bad == 0, "R3 cke/clk low in reset", cke_bad, 0);
            check(i_clk - i_rise == TS, "R4 reset-to-clock wait", i_clk - i_rise, TS);
            check(i_cke - i_clk == TC, "R4 clock-to-cke wait", i_cke - i_clk, TC);
            check(cke == NRANK'(rk), "R4 cke only present ranks", int'(cke), rk);
            check(i_req - i_cke == TX, "R5 cke-to-first-command", i_req - i_cke, TX);
            check(odt_bad == 0, "R10 odt held during run", odt_bad, 0);
            check(!odt_hold, "R10 odt released at end", int'(odt_hold), 0);
            check(busy_bad == 0 && !busy, "R13 busy span", busy_bad, 0);
            if (mode == 0) begin
                check(done && !error && err_code == 2'd0, "R6 done ok", int'(err_code), 0);
                check(nreq == 5, "R6 request count", nreq, 5);
                for (int k = 0; k < 5 && k < nreq; k++) begin
                    int e;
                    e = exp_word(k, aa, wr, cwl, two, r120);
                    if (k == 3)      check(words[k] == e, "R7 bank0 word", words[k], e);
                    else if (k == 2) check(words[k] == e, "R8 bank1 word", words[k], e);
                    else if (k < 2)  check(words[k] == e, "R9 bank2/3 word", words[k], e);
                    else             check(words[k] == e, "R6 ZQ word", words[k], e);
                end
            end else if (mode == 1) begin
                check(error && err_code == 2'd2, "R11 issuer error code", int'(err_code), 2);
                check(nreq == err_at + 1, "R11 stop after error", nreq, err_at + 1);
                for (int k = 0; k < 4; k++) begin
                    check(!cmd_req, "R11 no request after error", int'(cmd_req), 0);
                    @(negedge clk);
                end
            end else begin
                check(error && err_code == 2'd3, "R12 timeout code", int'(err_code), 3);
                check(req_hi == TO, "R12 request held length", req_hi, TO);
                check(nreq == 1, "R12 single request", nreq, 1);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reset_n && cke == '0 && !clk_en && !odt_hold, "R3 reset state pins", int'(cke), 0);
        check(!busy && !done && !error && !cmd_req, "R13 reset state status", int'(busy), 0);

        run_seq(1, 6, 6, 5, 1, 0, 0, 0, 0);
        run_seq(0, 6, 4, 5, 3, 0, 0, 0, 0);
        run_seq(0, 6, 17, 5, 3, 0, 0, 0, 0);
        run_seq(0, 3, 8, 5, 3, 0, 0, 0, 0);
        run_seq(0, 4, 5, 5, 1, 0, 0, 0, 0);
        run_seq(0, 19, 16, 12, 15, 1, 1, 0, 0);
        run_seq(0, 12, 15, 8, 5, 1, 0, 0, 0);
        run_seq(0, 11, 9, 7, 6, 0, 1, 1, 2);
        run_seq(0, 9, 10, 6, 2, 0, 0, 0, 0);
        run_seq(0, 9, 11, 6, 9, 1, 1, 2, 0);
        run_seq(1, 9, 11, 6, 9, 0, 0, 0, 0);
        for (int n = 0; n < 8; n++) begin
            run_seq(0, 4 + int'($urandom % 16), 5 + int'($urandom % 12),
                    5 + int'($urandom % 8), 1 + int'($urandom % 15),
                    1'($urandom % 2), 1'($urandom % 2), 0, 0);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule